// File: doc/BRIEF.md
# Multichannel DMA Enable and Interrupt Aggregator

This block is the control and interrupt front end of a multichannel transmit DMA engine. Software starts and stops channels through one shared enable vector. Channels are started through a set address and stopped through a clear address. Each address acts only on the bits written as one, so two drivers can each control their own channels without a read-modify-write race.

Each channel reports two kinds of event as single-cycle pulses: descriptor completion and error. The block latches every accepted event into a separate status register for each interrupt destination. Each of those status registers has its own mask. A summary word per destination shows which channels have a pending unmasked event. Any non-zero summary raises the interrupt line of that destination. Software clears status by writing back the value it read. The engine that moves the data sits outside this block.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Writing to address 0x0000 sets every enable bit written as 1 and leaves every bit written as 0 unchanged. Reading 0x0000 or 0x0004 returns the enable vector (bit n = channel n), which also drives ch_en_o, with the upper bits zero. The enable vector changes only on such writes.
- R2: Writing to address 0x0004 clears every enable bit written as 1 and leaves every bit written as 0 unchanged.
- R3: Channel n has a window at 0x8000 + 0x400*n. Within it, the status of destination d is at +0x10 + 4*d and the mask of destination d is at +0x20 + 4*d. Only bit 0 (descriptor done) and bit 6 (error) are stored, and all other bits read as zero.
- R4: A done pulse on an enabled channel sets status bit 0 of that channel in all destinations. An error pulse sets bit 6.
- R5: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. An interrupt line only falls after a register write.
- R6: An event pulse in the same cycle as a clearing write to the same status bit leaves the bit set.
- R7: Event pulses from a channel whose enable bit is 0 change no status and no interrupt line.
- R8: The summary word of destination d is at 0x0030 + 4*d. Its bit n is 1 exactly when (status AND mask) of channel n for destination d is non-zero, and the bits above the channel count are zero.
- R9: irq_o[d] is 1 exactly when the summary word of destination d is non-zero.
- R10: After reset, the enable vector, all status and all mask registers are zero, and every interrupt line is low.
- R11: A read from an address not listed above, including a channel window at or above the channel count, returns zero. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| done_evt_i | input | N_CH | Descriptor-done pulse per channel |
| err_evt_i | input | N_CH | Error pulse per channel |
| ch_en_o | output | N_CH | Enable level per channel |
| irq_o | output | N_DEST | Interrupt line per destination |

## Verification
The enable vector is swept through all sixteen values for four channels. Each value is set, then partly cleared with a fixed pattern, which shows whether zero bits are truly left alone at both addresses. Event pulses are driven in sixteen done/error patterns against a mask pattern that varies with channel and destination, and every status, mask, summary and interrupt line is compared against a bench model. This separates a wrong destination from a wrong channel or a swapped bit. Partial write-back clears, coincident clear and event, events on disabled channels, and accesses to unmapped and out-of-range windows each isolate one of the narrower rules.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int DONE_BIT = 0;
  localparam int ERR_BIT  = 6;

  localparam logic [31:0] EN_SET_OFS = 32'h0000_0000;
  localparam logic [31:0] EN_CLR_OFS = 32'h0000_0004;
  localparam logic [31:0] SUM_BASE   = 32'h0000_0030;
  localparam logic [31:0] STAT_OFS   = 32'h0000_0010;
  localparam logic [31:0] MASK_OFS   = 32'h0000_0020;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_EN_SET,
    ACC_EN_CLR,
    ACC_SUM,
    ACC_STAT,
    ACC_MASK
  } acc_e;

  // stored pair {err, done} placed at its register bit positions
  function automatic logic [31:0] evt_word(logic [1:0] v);
    logic [31:0] w;
    w = '0;
    w[ERR_BIT]  = v[1];
    w[DONE_BIT] = v[0];
    return w;
  endfunction

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int N_DEST = 4,
  parameter int ADDR_W = 16,
  parameter int CH_W   = $clog2(N_CH),
  parameter int DEST_W = $clog2(N_DEST)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              kind_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [DEST_W-1:0] dest_o
);

  logic [31:0] a;
  logic [31:0] off;
  logic [31:0] win;

  always_comb begin
    a      = 32'(addr_i);
    off    = 32'(a[9:0]);
    win    = 32'(a[14:10]);
    kind_o = ACC_NONE;
    ch_o   = '0;
    dest_o = '0;
    if (a[1:0] == 2'b00) begin
      if (a[31:15] == '0) begin
        if (a == EN_SET_OFS) kind_o = ACC_EN_SET;
        else if (a == EN_CLR_OFS) kind_o = ACC_EN_CLR;
        else if (a >= SUM_BASE && a < SUM_BASE + 32'(4 * N_DEST)) begin
          kind_o = ACC_SUM;
          dest_o = DEST_W'((a - SUM_BASE) >> 2);
        end
      end else if (a[31:16] == '0 && win < 32'(N_CH)) begin
        ch_o = CH_W'(win);
        if (off >= STAT_OFS && off < STAT_OFS + 32'(4 * N_DEST)) begin
          kind_o = ACC_STAT;
          dest_o = DEST_W'((off - STAT_OFS) >> 2);
        end else if (off >= MASK_OFS && off < MASK_OFS + 32'(4 * N_DEST)) begin
          kind_o = ACC_MASK;
          dest_o = DEST_W'((off - MASK_OFS) >> 2);
        end
      end
    end
  end

endmodule

// File: rtl/dma_en_reg.sv
module dma_en_reg #(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [N_CH-1:0] bits_i,
  output logic [N_CH-1:0] en_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_o <= '0;
    else if (set_i) en_o <= en_o | bits_i;
    else if (clr_i) en_o <= en_o & ~bits_i;
  end

endmodule

// File: rtl/dma_chan_evt.sv
module dma_chan_evt #(
  parameter int N_DEST = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   done_i,
  input  logic                   err_i,
  input  logic [N_DEST-1:0]      st_clr_i,
  input  logic [N_DEST-1:0]      mk_we_i,
  input  logic [1:0]             wbits_i,
  output logic [N_DEST-1:0][1:0] status_o,
  output logic [N_DEST-1:0][1:0] mask_o,
  output logic [N_DEST-1:0]      pend_o
);

  logic [1:0] evt;
  assign evt = en_i ? {err_i, done_i} : 2'b00;

  for (genvar d = 0; d < N_DEST; d++) begin : g_dest
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_o[d] <= '0;
      // set wins over a coincident clear
      else status_o[d] <= (status_o[d] & ~(st_clr_i[d] ? wbits_i : 2'b00)) | evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         mask_o[d] <= '0;
      else if (mk_we_i[d]) mask_o[d] <= wbits_i;
    end

    assign pend_o[d] = |(status_o[d] & mask_o[d]);
  end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int N_DEST = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_CH-1:0]   done_evt_i,
  input  logic [N_CH-1:0]   err_evt_i,
  output logic [N_CH-1:0]   ch_en_o,
  output logic [N_DEST-1:0] irq_o
);

  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int DEST_W = (N_DEST > 1) ? $clog2(N_DEST) : 1;

  acc_e              kind;
  logic [CH_W-1:0]   ch_sel;
  logic [DEST_W-1:0] dest_sel;
  logic              wr;
  logic [1:0]        wbits;
  logic [N_DEST-1:0] dest_oh;

  logic [N_CH-1:0][N_DEST-1:0][1:0] st_all;
  logic [N_CH-1:0][N_DEST-1:0][1:0] mk_all;
  logic [N_CH-1:0][N_DEST-1:0]      pend_all;
  logic [N_DEST-1:0][N_CH-1:0]      sum;

  dma_irq_decode #(
    .N_CH(N_CH), .N_DEST(N_DEST), .ADDR_W(ADDR_W), .CH_W(CH_W), .DEST_W(DEST_W)
  ) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .ch_o   (ch_sel),
    .dest_o (dest_sel)
  );

  assign wr      = req_i & we_i;
  assign wbits   = {wdata_i[ERR_BIT], wdata_i[DONE_BIT]};
  assign dest_oh = N_DEST'(1) << dest_sel;

  dma_en_reg #(.N_CH(N_CH)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr && kind == ACC_EN_SET),
    .clr_i  (wr && kind == ACC_EN_CLR),
    .bits_i (wdata_i[N_CH-1:0]),
    .en_o   (ch_en_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr && (ch_sel == CH_W'(c));

    dma_chan_evt #(.N_DEST(N_DEST)) u_evt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ch_en_o[c]),
      .done_i   (done_evt_i[c]),
      .err_i    (err_evt_i[c]),
      .st_clr_i ((hit && kind == ACC_STAT) ? dest_oh : '0),
      .mk_we_i  ((hit && kind == ACC_MASK) ? dest_oh : '0),
      .wbits_i  (wbits),
      .status_o (st_all[c]),
      .mask_o   (mk_all[c]),
      .pend_o   (pend_all[c])
    );

    for (genvar d = 0; d < N_DEST; d++) begin : g_sum
      assign sum[d][c] = pend_all[c][d];
    end
  end

  for (genvar d = 0; d < N_DEST; d++) begin : g_irq
    assign irq_o[d] = |sum[d];
  end

  always_comb begin
    unique case (kind)
      ACC_EN_SET, ACC_EN_CLR: rdata_o = 32'(ch_en_o);
      ACC_SUM:                rdata_o = 32'(sum[dest_sel]);
      ACC_STAT:               rdata_o = evt_word(st_all[ch_sel][dest_sel]);
      ACC_MASK:               rdata_o = evt_word(mk_all[ch_sel][dest_sel]);
      default:                rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
  parameter int N_CH   = 4,
  parameter int N_DEST = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [N_CH-1:0]   done_evt_i,
  input logic [N_CH-1:0]   err_evt_i,
  input logic [N_CH-1:0]   ch_en_o,
  input logic [N_DEST-1:0] irq_o
);

  logic            wr;
  logic [N_CH-1:0] wb;
  assign wr = req_i && we_i;
  assign wb = wdata_i[N_CH-1:0];

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == '0 |=> ((ch_en_o & $past(wb)) == $past(wb)) &&
      (((ch_en_o ^ $past(ch_en_o)) & ~$past(wb)) == '0)); // R1

  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(4) |=> ((ch_en_o & $past(wb)) == '0) &&
      (((ch_en_o ^ $past(ch_en_o)) & ~$past(wb)) == '0)); // R2

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(ch_en_o)); // R1

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr && (((done_evt_i | err_evt_i) & ch_en_o) == '0) |=> $stable(irq_o)); // R7

  for (genvar d = 0; d < N_DEST; d++) begin : g_d
    AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[d]) |-> $past(wr)); // R5
  end

endmodule

bind dma_irq_ctrl dma_irq_chk #(
  .N_CH(N_CH), .N_DEST(N_DEST), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .done_evt_i (done_evt_i),
  .err_evt_i  (err_evt_i),
  .ch_en_o    (ch_en_o),
  .irq_o      (irq_o)
);

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;

  localparam int NC = 4;
  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC-1:0] done_e = '0;
  logic [NC-1:0] err_e = '0;
  logic [NC-1:0] ch_en;
  logic [ND-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [NC-1:0] m_en;
  logic [1:0]    m_st[NC][ND];
  logic [1:0]    m_mk[NC][ND];

  always #5 clk = ~clk;

  dma_irq_ctrl #(.N_CH(NC), .N_DEST(ND), .ADDR_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_evt_i(done_e), .err_evt_i(err_e),
    .ch_en_o(ch_en), .irq_o(irq)
  );

  function automatic logic [31:0] word(logic [1:0] v);
    return (32'(v[1]) << 6) | 32'(v[0]);
  endfunction

  function automatic logic [15:0] st_addr(int c, int d);
    return 16'(32'h8000 + 32'h400 * c + 32'h10 + 4 * d);
  endfunction

  function automatic logic [15:0] mk_addr(int c, int d);
    return 16'(32'h8000 + 32'h400 * c + 32'h20 + 4 * d);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic model_evt(logic [NC-1:0] dn, logic [NC-1:0] er);
    for (int c = 0; c < NC; c++)
      if (m_en[c])
        for (int d = 0; d < ND; d++) m_st[c][d] |= {er[c], dn[c]};
  endtask

  task automatic pulse(logic [NC-1:0] dn, logic [NC-1:0] er);
    @(negedge clk);
    done_e = dn; err_e = er;
    @(negedge clk);
    done_e = '0; err_e = '0;
    model_evt(dn, er);
  endtask

  task automatic verify_all(string tag);
    logic [31:0] v;
    logic [NC-1:0] s;
    rd(16'h0000, v); check({tag, "/R1 en"}, v, 32'(m_en));
    check({tag, "/R1 ch_en_o"}, 32'(ch_en), 32'(m_en));
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < ND; d++) begin
        rd(st_addr(c, d), v); check({tag, "/R3 status"}, v, word(m_st[c][d]));
        rd(mk_addr(c, d), v); check({tag, "/R3 mask"}, v, word(m_mk[c][d]));
      end
    for (int d = 0; d < ND; d++) begin
      s = '0;
      for (int c = 0; c < NC; c++) s[c] = |(m_st[c][d] & m_mk[c][d]);
      rd(16'(32'h30 + 4 * d), v); check({tag, "/R8 summary"}, v, 32'(s));
      check({tag, "/R9 irq"}, 32'(irq[d]), 32'(s != '0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_en = '0;
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < ND; d++) begin m_st[c][d] = '0; m_mk[c][d] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    verify_all("R10");

    // R1 / R2 enable sweep
    for (int p = 0; p < 16; p++) begin
      wr(16'h0004, 32'hF); m_en = '0;
      wr(16'h0000, 32'(p)); m_en = 4'(p);
      rd(16'h0000, v); check("R1 set", v, 32'(m_en));
      wr(16'h0000, 32'h0);
      rd(16'h0004, v); check("R1 zero write", v, 32'(m_en));
      wr(16'h0004, 32'h5); m_en &= ~4'h5;
      rd(16'h0000, v); check("R2 clear", v, 32'(m_en));
      check("R2 ch_en_o", 32'(ch_en), 32'(m_en));
    end

    // R3 mask only keeps bits 0 and 6
    wr(mk_addr(2, 1), 32'hFFFF_FFFF);
    rd(mk_addr(2, 1), v); check("R3 mask all ones", v, 32'h41);
    wr(mk_addr(2, 1), 32'hFFFF_FFBE);
    rd(mk_addr(2, 1), v); check("R3 mask other bits", v, 32'h0);

    // mask pattern varying with channel and destination
    wr(16'h0000, 32'hF); m_en = 4'hF;
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < ND; d++) begin
        m_mk[c][d] = 2'((c + d) % 4);
        wr(mk_addr(c, d), word(m_mk[c][d]));
      end

    // R4 / R5 / R8 / R9 event sweep
    for (int p = 0; p < 16; p++) begin
      pulse(4'(p), 4'(p * 5 + 3));
      verify_all("R4");
      for (int c = 0; c < NC; c++)
        for (int d = 0; d < ND; d++) begin
          wr(st_addr(c, d), word(2'((p + c + d) % 4)) | 32'hFFFF_FF00);
          m_st[c][d] &= ~2'((p + c + d) % 4);
        end
      verify_all("R5");
    end

    // R7 disabled channels ignored
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < ND; d++) begin wr(st_addr(c, d), 32'h41); m_st[c][d] = '0; end
    wr(16'h0004, 32'hA); m_en = 4'h5;
    pulse(4'hF, 4'hF);
    verify_all("R7");
    wr(16'h0004, 32'h5); m_en = '0;
    pulse(4'hF, 4'hF);
    verify_all("R7 all off");

    // R6 coincident clear and event
    wr(16'h0000, 32'h1); m_en = 4'h1;
    pulse(4'h1, 4'h1);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = st_addr(0, 0); wdata = 32'h41; done_e = 4'h1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; done_e = '0;
    m_st[0][0] &= ~2'b11;
    model_evt(4'h1, 4'h0);
    rd(st_addr(0, 0), v); check("R6 set wins", v, 32'h01);
    verify_all("R6");

    // R11 unmapped addresses
    rd(16'h0008, v); check("R11 read gap", v, 32'h0);
    rd(16'h9410, v); check("R11 read channel out of range", v, 32'h0);
    rd(16'h8011, v); check("R11 read misaligned", v, 32'h0);
    wr(16'h0008, 32'hF);
    wr(16'h0040, 32'hF);
    wr(16'h8030, 32'h41);
    verify_all("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule